// File: doc/BRIEF.md
# Two-Stage DMA Channel Trigger Router

This block links pairs of DMA channels so that progress on one channel (the feeder) starts another channel (the follower) with no software involvement. Each of `NCH` channels carries a small configuration held in the router: a role code that makes the channel a feeder or a follower of one of two independent chains, and a fire code that picks the level of the transfer hierarchy whose completion releases the follower. Those levels are fragment, block, transaction and linked-list.

The data movers stay outside. They report completions as one-cycle pulses on four per-channel vectors. The router answers with a one-cycle start pulse on the follower channel of the same chain. Configuration is written as the combined 32-bit flags word that the channel's descriptor already uses. A package provides functions that pack and unpack this word. Inconsistent or out-of-range configuration is reported on a sticky error flag.

Top module: `stage_chain_router`

## Requirements
- R1: The flags word holds the role code in bits [31:24], the fire code in bits [23:16], the request mode in bits [15:8] and the interrupt type in bits [7:0]. The package pack function places the four fields at these positions, and the unpack function returns them unchanged.
- R2: Role codes are 0 idle, 1 feeder of chain A, 2 feeder of chain B, 3 follower of chain A and 4 follower of chain B. A chain is active only when it has both a feeder and a follower.
- R3: Fire codes are 0 off, 1 fragment done, 2 block done, 3 transaction done and 4 list done. Only the done pulse of the level selected on the feeder starts the follower. The other levels, and done pulses on the follower itself, have no effect.
- R4: A start pulse appears in the cycle after the qualifying done pulse and lasts one cycle. Every qualifying event produces its own pulse, so done pulses on consecutive cycles give start pulses on consecutive cycles.
- R5: The two chains are independent. Events of chain A never start the follower of chain B, and the reverse holds too. Both chains can fire in the same cycle.
- R6: A channel with role 0 is never started, and its done pulses start no channel.
- R7: A fire code of 0 on the feeder suppresses every start of that chain.
- R8: When several channels claim the same role in the same chain, the lowest-numbered channel takes the role, and `cfg_err` is set one cycle after the conflicting configuration is in place.
- R9: A role code or fire code above 4 is stored as 0 and sets `cfg_err` in the cycle after the write.
- R10: After reset, no start pulse is active, `cfg_err` is 0 and all channels are idle. Once set, `cfg_err` stays set until the next reset.
- R11: A configuration write takes effect in the cycle after the write. A done pulse in the same cycle as the write is judged against the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write strobe for one channel's configuration |
| cfg_sel | input | CH_W | Channel written by `cfg_we` |
| cfg_flags | input | 32 | Combined flags word (role, fire, request, interrupt) |
| frag_done | input | NCH | Per-channel fragment-done pulses |
| blk_done | input | NCH | Per-channel block-done pulses |
| xfer_done | input | NCH | Per-channel transaction-done pulses |
| list_done | input | NCH | Per-channel linked-list-done pulses |
| stage_start | output | NCH | Per-channel one-cycle start pulses |
| cfg_err | output | 1 | Sticky configuration error flag |

## Verification
The hardest case to reach is a done pulse that lands in the same cycle as a write that changes the feeder. Two others are close behind: a role collision, where the lower-numbered channel must win while a higher one also pulses, and a pulse on a channel that holds a rejected code. In each of these the start vector must still follow the configuration that applied before the edge. Directed sequences build these cases on purpose. They also pulse every level on every channel at once. Fixed-seed random traffic then mixes writes, including occasional invalid codes, with dense done pulses. A reference model checks every cycle.

// File: rtl/stage_chain_pkg.sv
package stage_chain_pkg;

  localparam int FLAGS_W  = 32;
  localparam int FIELD_W  = 8;
  localparam int CODE_W   = 3;
  localparam int MAX_CODE = 4;

  typedef enum logic [CODE_W-1:0] {
    ROLE_IDLE  = 3'd0,
    ROLE_SRC_A = 3'd1,
    ROLE_SRC_B = 3'd2,
    ROLE_DST_A = 3'd3,
    ROLE_DST_B = 3'd4
  } role_e;

  typedef enum logic [CODE_W-1:0] {
    FIRE_OFF   = 3'd0,
    FIRE_FRAG  = 3'd1,
    FIRE_BLOCK = 3'd2,
    FIRE_XFER  = 3'd3,
    FIRE_LIST  = 3'd4
  } fire_e;

  // Field order is fixed: the descriptor decoder reads role at [31:24].
  typedef struct packed {
    logic [FIELD_W-1:0] role;
    logic [FIELD_W-1:0] fire;
    logic [FIELD_W-1:0] req;
    logic [FIELD_W-1:0] irq;
  } flags_t;

  function automatic logic [FLAGS_W-1:0] pack_flags(
    input logic [FIELD_W-1:0] role,
    input logic [FIELD_W-1:0] fire,
    input logic [FIELD_W-1:0] req,
    input logic [FIELD_W-1:0] irq
  );
    flags_t w;
    w.role = role;
    w.fire = fire;
    w.req  = req;
    w.irq  = irq;
    return w;
  endfunction

  function automatic flags_t unpack_flags(input logic [FLAGS_W-1:0] word);
    return flags_t'(word);
  endfunction

  function automatic logic code_ok(input logic [FIELD_W-1:0] code);
    return code <= FIELD_W'(MAX_CODE);
  endfunction

endpackage

// File: rtl/stage_chain_cfg.sv
module stage_chain_cfg
  import stage_chain_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [CH_W-1:0]               wr_sel,
  input  logic [FLAGS_W-1:0]            wr_flags,
  output logic [NCH-1:0][CODE_W-1:0]    role_q,
  output logic [NCH-1:0][CODE_W-1:0]    fire_q,
  output logic                          bad_wr
);

  flags_t                       fl;
  logic                         sel_ok;
  logic                         role_ok;
  logic                         fire_ok;
  logic                         upd;
  logic [NCH-1:0][CODE_W-1:0]   role_d;
  logic [NCH-1:0][CODE_W-1:0]   fire_d;

  assign fl      = unpack_flags(wr_flags);
  assign sel_ok  = int'(wr_sel) < NCH;
  assign role_ok = code_ok(fl.role);
  assign fire_ok = code_ok(fl.fire);
  assign upd     = wr_en && sel_ok;
  assign bad_wr  = upd && !(role_ok && fire_ok);

  // Out-of-range codes are stored as 0 so later decode never sees them.
  always_comb begin
    role_d = role_q;
    fire_d = fire_q;
    if (upd) begin
      role_d[wr_sel] = role_ok ? fl.role[CODE_W-1:0] : ROLE_IDLE;
      fire_d[wr_sel] = fire_ok ? fl.fire[CODE_W-1:0] : FIRE_OFF;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      role_q <= '0;
      fire_q <= '0;
    end else if (upd) begin
      role_q <= role_d;
      fire_q <= fire_d;
    end
  end

endmodule

// File: rtl/stage_chain_group.sv
module stage_chain_group
  import stage_chain_pkg::*;
#(
  parameter int                NCH      = 8,
  parameter int                CH_W     = $clog2(NCH),
  parameter logic [CODE_W-1:0] SRC_CODE = 3'd1,
  parameter logic [CODE_W-1:0] DST_CODE = 3'd3
) (
  input  logic [NCH-1:0][CODE_W-1:0] role_q,
  input  logic [NCH-1:0][CODE_W-1:0] fire_q,
  input  logic [NCH-1:0]             frag_done,
  input  logic [NCH-1:0]             blk_done,
  input  logic [NCH-1:0]             xfer_done,
  input  logic [NCH-1:0]             list_done,
  output logic [NCH-1:0]             start_d,
  output logic                       dup
);

  logic [NCH-1:0] src_m;
  logic [NCH-1:0] dst_m;
  logic [CH_W-1:0] src_idx;
  logic [CH_W-1:0] dst_idx;
  logic            evt;

  for (genvar i = 0; i < NCH; i++) begin : g_match
    assign src_m[i] = role_q[i] == SRC_CODE;
    assign dst_m[i] = role_q[i] == DST_CODE;
  end

  // Lowest-numbered claimant wins: scan downward so the last hit is lowest.
  always_comb begin
    src_idx = '0;
    dst_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (src_m[i]) src_idx = CH_W'(i);
      if (dst_m[i]) dst_idx = CH_W'(i);
    end
  end

  always_comb begin
    case (fire_q[src_idx])
      FIRE_FRAG:  evt = frag_done[src_idx];
      FIRE_BLOCK: evt = blk_done[src_idx];
      FIRE_XFER:  evt = xfer_done[src_idx];
      FIRE_LIST:  evt = list_done[src_idx];
      default:    evt = 1'b0;
    endcase
  end

  assign start_d = (|src_m && |dst_m && evt) ? (NCH'(1) << dst_idx) : '0;
  assign dup     = ($countones(src_m) > 1) || ($countones(dst_m) > 1);

endmodule

// File: rtl/stage_chain_router.sv
module stage_chain_router
  import stage_chain_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CH_W-1:0]    cfg_sel,
  input  logic [FLAGS_W-1:0] cfg_flags,
  input  logic [NCH-1:0]     frag_done,
  input  logic [NCH-1:0]     blk_done,
  input  logic [NCH-1:0]     xfer_done,
  input  logic [NCH-1:0]     list_done,
  output logic [NCH-1:0]     stage_start,
  output logic               cfg_err
);

  localparam int NGRP = 2;

  logic [NCH-1:0][CODE_W-1:0] role_q;
  logic [NCH-1:0][CODE_W-1:0] fire_q;
  logic                       bad_wr;
  logic [NGRP-1:0][NCH-1:0]   grp_start;
  logic [NGRP-1:0]            grp_dup;
  logic [NCH-1:0]             start_d;
  logic                       err_d;

  stage_chain_cfg #(.NCH(NCH), .CH_W(CH_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_sel   (cfg_sel),
    .wr_flags (cfg_flags),
    .role_q   (role_q),
    .fire_q   (fire_q),
    .bad_wr   (bad_wr)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    stage_chain_group #(
      .NCH      (NCH),
      .CH_W     (CH_W),
      .SRC_CODE (CODE_W'(ROLE_SRC_A + g)),
      .DST_CODE (CODE_W'(ROLE_DST_A + g))
    ) u_grp (
      .role_q    (role_q),
      .fire_q    (fire_q),
      .frag_done (frag_done),
      .blk_done  (blk_done),
      .xfer_done (xfer_done),
      .list_done (list_done),
      .start_d   (grp_start[g]),
      .dup       (grp_dup[g])
    );
  end

  always_comb begin
    start_d = '0;
    for (int g = 0; g < NGRP; g++) start_d = start_d | grp_start[g];
    err_d = cfg_err | bad_wr | (|grp_dup);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_start <= '0;
      cfg_err     <= 1'b0;
    end else begin
      stage_start <= start_d;
      cfg_err     <= err_d;
    end
  end

endmodule

module stage_chain_router_chk #(
  parameter int NCH  = 8,
  parameter int CH_W = $clog2(NCH)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [CH_W-1:0] cfg_sel,
  input logic [31:0]     cfg_flags,
  input logic [NCH-1:0]  frag_done,
  input logic [NCH-1:0]  blk_done,
  input logic [NCH-1:0]  xfer_done,
  input logic [NCH-1:0]  list_done,
  input logic [NCH-1:0]  stage_start,
  input logic            cfg_err
);

  logic any_done;
  logic bad_code_wr;
  assign any_done    = |(frag_done | blk_done | xfer_done | list_done);
  assign bad_code_wr = cfg_we && (int'(cfg_sel) < NCH) &&
                       ((cfg_flags[31:24] > 8'd4) || (cfg_flags[23:16] > 8'd4));

  a_r4_start_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    (|stage_start) |-> $past(any_done));

  a_r5_one_follower_per_chain: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stage_start) <= 2);

  a_r9_bad_code_flags: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code_wr |=> cfg_err);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

endmodule

bind stage_chain_router stage_chain_router_chk #(.NCH(NCH), .CH_W(CH_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_sel     (cfg_sel),
  .cfg_flags   (cfg_flags),
  .frag_done   (frag_done),
  .blk_done    (blk_done),
  .xfer_done   (xfer_done),
  .list_done   (list_done),
  .stage_start (stage_start),
  .cfg_err     (cfg_err)
);

// File: tb/stage_chain_router_tb.sv
`timescale 1ns/1ps
module stage_chain_router_tb;
  import stage_chain_pkg::*;

  localparam int NCH  = 8;
  localparam int CH_W = $clog2(NCH);

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cfg_we;
  logic [CH_W-1:0] cfg_sel;
  logic [31:0]     cfg_flags;
  logic [NCH-1:0]  frag_done, blk_done, xfer_done, list_done;
  logic [NCH-1:0]  stage_start;
  logic            cfg_err;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  int role_m [NCH];
  int fire_m [NCH];
  logic err_m;

  always #2 clk = ~clk;

  stage_chain_router #(.NCH(NCH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_flags(cfg_flags), .frag_done(frag_done), .blk_done(blk_done),
    .xfer_done(xfer_done), .list_done(list_done),
    .stage_start(stage_start), .cfg_err(cfg_err)
  );

  function automatic logic [31:0] mk(input int role, input int fire);
    return (32'(role) << 24) | (32'(fire) << 16) | 32'h0000_0102;
  endfunction

  function automatic logic [NCH-1:0] exp_start(input logic [NCH-1:0] f, b, x, l);
    logic [NCH-1:0] r;
    r = '0;
    for (int g = 0; g < 2; g++) begin
      int s;
      int d;
      logic e;
      s = -1;
      d = -1;
      e = 1'b0;
      for (int i = NCH - 1; i >= 0; i--) begin
        if (role_m[i] == 1 + g) s = i;
        if (role_m[i] == 3 + g) d = i;
      end
      if (s >= 0 && d >= 0) begin
        case (fire_m[s])
          1: e = f[s];
          2: e = b[s];
          3: e = x[s];
          4: e = l[s];
          default: e = 1'b0;
        endcase
        if (e) r[d] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic model_dup();
    logic d;
    d = 1'b0;
    for (int c = 1; c <= 4; c++) begin
      int n;
      n = 0;
      for (int i = 0; i < NCH; i++) if (role_m[i] == c) n++;
      if (n > 1) d = 1'b1;
    end
    return d;
  endfunction

  task automatic check_v(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input string tag, input logic we, input int sel, input logic [31:0] fl,
                     input logic [NCH-1:0] f, input logic [NCH-1:0] b,
                     input logic [NCH-1:0] x, input logic [NCH-1:0] l);
    logic [NCH-1:0] es;
    logic ee;
    cfg_we = we; cfg_sel = CH_W'(sel); cfg_flags = fl;
    frag_done = f; blk_done = b; xfer_done = x; list_done = l;
    es = exp_start(f, b, x, l);
    ee = err_m | model_dup() | (we && (fl[31:24] > 8'd4 || fl[23:16] > 8'd4));
    if (we) begin
      role_m[sel] = (fl[31:24] > 8'd4) ? 0 : int'(fl[31:24]);
      fire_m[sel] = (fl[23:16] > 8'd4) ? 0 : int'(fl[23:16]);
    end
    err_m = ee;
    @(posedge clk);
    @(negedge clk);
    check_v({tag, " start"}, 32'(stage_start), 32'(es));
    check_v({tag, " err"}, 32'(cfg_err), 32'(ee));
  endtask

  task automatic wr(input string tag, input int sel, input int role, input int fire);
    cyc(tag, 1'b1, sel, mk(role, fire), '0, '0, '0, '0);
  endtask

  task automatic pulse(input string tag, input logic [NCH-1:0] f, input logic [NCH-1:0] b,
                       input logic [NCH-1:0] x, input logic [NCH-1:0] l);
    cyc(tag, 1'b0, 0, 32'h0, f, b, x, l);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_we = 1'b0; cfg_sel = '0; cfg_flags = '0;
    frag_done = '0; blk_done = '0; xfer_done = '0; list_done = '0;
    for (int i = 0; i < NCH; i++) begin role_m[i] = 0; fire_m[i] = 0; end
    err_m = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_v("R10 reset start", 32'(stage_start), 32'h0);
    check_v("R10 reset err", 32'(cfg_err), 32'h0);
  endtask

  initial begin
    flags_t u;
    int seed;
    seed = $urandom(32'd20240611);
    do_reset();

    // R1 helper layout
    check_v("R1 pack", pack_flags(8'd3, 8'd2, 8'd1, 8'd7), 32'h0302_0107);
    u = unpack_flags(32'h0401_0305);
    check_v("R1 unpack", {u.role, u.fire, u.req, u.irq}, 32'h0401_0305);

    // R2 / R3: chain A, feeder ch2 on block, follower ch5
    wr("R2 cfg", 2, 1, 2);
    pulse("R2 half chain", '0, 8'h04, '0, '0);
    wr("R2 cfg", 5, 3, 0);
    pulse("R3 wrong level", 8'h04, '0, 8'h04, 8'h04);
    pulse("R3 block fires", '0, 8'h04, '0, '0);
    pulse("R4 one wide", '0, '0, '0, '0);
    pulse("R4 back to back", '0, 8'h04, '0, '0);
    pulse("R4 back to back", '0, 8'h04, '0, '0);
    pulse("R3 follower done", 8'h20, 8'h20, 8'h20, 8'h20);

    // R5: chain B, feeder ch1 on list, follower ch6
    wr("R5 cfg", 1, 2, 4);
    wr("R5 cfg", 6, 4, 1);
    pulse("R5 chain B only", '0, '0, '0, 8'h02);
    pulse("R5 both chains", '0, 8'h04, '0, 8'h02);
    pulse("R6 idle ch0", 8'h01, 8'h01, 8'h01, 8'h01);
    pulse("R6 all ones", '1, '1, '1, '1);

    // R11: write and event in the same cycle use the old setting
    cyc("R11 same cycle", 1'b1, 2, mk(1, 0), '0, 8'h04, '0, '0);
    pulse("R7 fire off", '1, '1, '1, '1);

    // R8: collision on feeder of chain A, ch2 (fire off) wins over ch3
    wr("R8 cfg", 3, 1, 1);
    pulse("R8 lowest wins", 8'h08, 8'h08, '0, '0);
    pulse("R8 lowest wins", 8'h0C, '0, '0, '0);

    // R9: invalid codes, after a fresh reset
    do_reset();
    wr("R9 cfg", 3, 3, 0);
    wr("R9 bad fire", 4, 1, 7);
    pulse("R9 fire as off", '1, '1, '1, '1);
    wr("R9 bad role", 4, 6, 1);
    wr("R9 cfg", 6, 1, 1);
    pulse("R9 role as idle", 8'h50, '0, '0, '0);
    pulse("R10 sticky", '0, '0, '0, '0);

    // Random traffic
    do_reset();
    for (int n = 0; n < 3000; n++) begin
      logic [NCH-1:0] f, b, x, l;
      f = NCH'($urandom) & NCH'($urandom);
      b = NCH'($urandom) & NCH'($urandom);
      x = NCH'($urandom) & NCH'($urandom);
      l = NCH'($urandom) & NCH'($urandom);
      if ($urandom_range(0, 99) < 20) begin
        int role, fire;
        role = ($urandom_range(0, 99) < 5) ? $urandom_range(5, 7) : $urandom_range(0, 4);
        fire = ($urandom_range(0, 99) < 5) ? $urandom_range(5, 7) : $urandom_range(0, 4);
        cyc("R4 random", 1'b1, $urandom_range(0, NCH - 1), mk(role, fire), f, b, x, l);
      end else begin
        cyc("R3 random", 1'b0, 0, 32'h0, f, b, x, l);
      end
      if (n == 1500) do_reset();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule